// File: doc/BRIEF.md
# Coprocessor Bus Address Decoder with Open-Bus Latch

This block sits on the memory bus of a coprocessor and turns each 24-bit address into a select for one of three targets: a 2 KiB internal work RAM, the bitmap RAM port, and a single "other" target that stands for ROM. The decoder does not hold the memories. Each target returns its byte on its own read-data input. The decoder picks the byte that belongs to the address and registers it toward the CPU.

The work RAM appears in a 4 KiB window but only has 2 KiB behind it. The upper half of that window is a hole. A read there gives zero. A write there reaches no target, but it still counts as a bus cycle to a mapped region.

An address that no region claims is open bus. A read from it returns the last value the bus carried. That value lives in a latch, which is loaded by:
- every read, and
- every write that lands in a mapped region.

Top module: `cpbus_decoder`

## Requirements
- R1: Work RAM region. Banks 0x00-0x3F and 0x80-0xBF, offsets 0x0000-0x07FF, assert `iram_sel` while a strobe is high. `iram_addr` equals address bits 10:0. A read returns `iram_rdata` on `cpu_rdata` after the next rising clock edge.
- R2: Work RAM hole. Offsets 0x0800-0x0FFF of the same banks assert no select and never assert `iram_we`. A read there returns 0x00 one cycle later.
- R3: Bitmap region. Banks 0x00-0x3F and 0x80-0xBF at offsets 0x6000-0x7FFF, and banks 0x60-0x6F at any offset, assert `bmp_sel`. A read returns `bmp_rdata`.
- R4: Other region. Banks 0x00-0x3F and 0x80-0xBF at offsets 0x8000-0xFFFF, and banks 0xC0-0xFF at any offset, assert `other_sel`. A read returns `other_rdata`.
- R5: Selects. At most one select is high at a time. All selects are low when neither strobe is high. A write-enable is high only when `cpu_wr` is high and `cpu_rd` is low.
- R6: A read from any mapped region (the hole included) loads the returned byte into the open-bus latch.
- R7: A write (`cpu_wr` high, `cpu_rd` low) to a mapped region, the hole included, loads `cpu_wdata` into the open-bus latch.
- R8: A read that hits no region returns the open-bus latch contents one cycle later.
- R9: A write that hits no region leaves the latch unchanged. When both strobes are high, the cycle is treated as a read only and the write is ignored.
- R10: After reset, `cpu_rdata` and the open-bus latch are 0x00.
- R11: `cpu_rdata` changes only on the clock edge that follows a cycle with `cpu_rd` high. Writes do not disturb it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 24 | Bus address: bank in bits 23:16, offset in bits 15:0 |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data toward the CPU |
| tgt_wdata | output | 8 | Write data forwarded to all targets |
| iram_sel | output | 1 | Work RAM select |
| iram_we | output | 1 | Work RAM write enable |
| iram_addr | output | 11 | Work RAM byte index |
| iram_rdata | input | 8 | Work RAM read data |
| bmp_sel | output | 1 | Bitmap port select |
| bmp_we | output | 1 | Bitmap port write enable |
| bmp_rdata | input | 8 | Bitmap port read data |
| other_sel | output | 1 | Other-target select |
| other_we | output | 1 | Other-target write enable |
| other_rdata | input | 8 | Other-target read data |

## Verification
The assertions check the following on every cycle:
- selects are mutually exclusive and drop without a strobe;
- the hole never raises a write enable and reads back zero;
- `cpu_rdata` holds when no read is presented;
- the latch follows mapped writes and ignores unmapped ones;
- unmapped reads return the latch.

Only the bench's scenarios can show the rest:
- that every bank and offset class lands in the right region across the full bank sweep;
- that each target's byte arrives a cycle later;
- that the latch contents seen through later unmapped reads reflect the exact history of earlier mapped reads and writes.

// File: rtl/cpbus_pkg.sv
package cpbus_pkg;

  typedef enum logic [2:0] {
    RGN_NONE  = 3'd0,
    RGN_IRAM  = 3'd1,
    RGN_HOLE  = 3'd2,
    RGN_BMP   = 3'd3,
    RGN_OTHER = 3'd4
  } rgn_e;

  // Bank and offset split of the bus address
  localparam int BANK_W = 8;
  localparam int OFF_W  = 16;

  // Offset boundaries in the low/mirror banks
  localparam logic [3:0] IRAM_OFF_HI4  = 4'h0;  // offset 0x0xxx
  localparam logic [2:0] BMP_OFF_HI3   = 3'b011; // offset 0x6000-0x7FFF
  localparam logic [3:0] BMP_BANK_HI4  = 4'h6;  // banks 0x60-0x6F
  localparam logic [1:0] ROM_BANK_HI2  = 2'b11; // banks 0xC0-0xFF

endpackage

// File: rtl/cpbus_region_decode.sv
module cpbus_region_decode
  import cpbus_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int IRAM_AW = 11
) (
  input  logic [ADDR_W-1:0] addr,
  output rgn_e              region
);

  localparam int BANK_LSB = ADDR_W - BANK_W;

  logic [BANK_W-1:0] bank;
  logic [OFF_W-1:0]  off;
  logic              low_bank;
  logic              hit_iram_win;
  logic              hit_bmp;
  logic              hit_other;

  always_comb begin
    bank = addr[ADDR_W-1:BANK_LSB];
    off  = addr[OFF_W-1:0];
    // banks 00-3F and 80-BF share bit 6 clear
    low_bank     = ~bank[BANK_W-2];
    hit_iram_win = low_bank && (off[OFF_W-1:OFF_W-4] == IRAM_OFF_HI4);
    hit_bmp      = (low_bank && (off[OFF_W-1:OFF_W-3] == BMP_OFF_HI3)) ||
                   (bank[BANK_W-1:BANK_W-4] == BMP_BANK_HI4);
    hit_other    = (low_bank && off[OFF_W-1]) ||
                   (bank[BANK_W-1:BANK_W-2] == ROM_BANK_HI2);
  end

  always_comb begin
    region = RGN_NONE;
    if (hit_iram_win) begin
      region = off[IRAM_AW] ? RGN_HOLE : RGN_IRAM;
    end else if (hit_bmp) begin
      region = RGN_BMP;
    end else if (hit_other) begin
      region = RGN_OTHER;
    end
  end

endmodule

// File: rtl/cpbus_read_mux.sv
module cpbus_read_mux
  import cpbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  rgn_e              region,
  input  logic [DATA_W-1:0] iram_rdata,
  input  logic [DATA_W-1:0] bmp_rdata,
  input  logic [DATA_W-1:0] other_rdata,
  input  logic [DATA_W-1:0] openbus,
  output logic [DATA_W-1:0] value,
  output logic              mapped
);

  always_comb begin
    mapped = 1'b1;
    unique case (region)
      RGN_IRAM:  value = iram_rdata;
      RGN_HOLE:  value = '0;
      RGN_BMP:   value = bmp_rdata;
      RGN_OTHER: value = other_rdata;
      default: begin
        value  = openbus;
        mapped = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/cpbus_openbus.sv
module cpbus_openbus #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic              wr,
  input  logic              mapped,
  input  logic [DATA_W-1:0] rd_value,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] openbus_q,
  output logic [DATA_W-1:0] rdata_q
);

  logic              ob_en;
  logic [DATA_W-1:0] ob_d;
  logic              rdata_en;

  always_comb begin
    rdata_en = rd;
    ob_en    = 1'b0;
    ob_d     = openbus_q;
    if (rd) begin
      ob_en = 1'b1;
      ob_d  = rd_value;
    end else if (wr && mapped) begin
      ob_en = 1'b1;
      ob_d  = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      openbus_q <= '0;
    end else if (ob_en) begin
      openbus_q <= ob_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rdata_en) begin
      rdata_q <= rd_value;
    end
  end

endmodule

// File: rtl/cpbus_decoder.sv
module cpbus_decoder
  import cpbus_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 8,
  parameter int IRAM_AW = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic               cpu_rd,
  input  logic               cpu_wr,
  input  logic [DATA_W-1:0]  cpu_wdata,
  output logic [DATA_W-1:0]  cpu_rdata,
  output logic [DATA_W-1:0]  tgt_wdata,
  output logic               iram_sel,
  output logic               iram_we,
  output logic [IRAM_AW-1:0] iram_addr,
  input  logic [DATA_W-1:0]  iram_rdata,
  output logic               bmp_sel,
  output logic               bmp_we,
  input  logic [DATA_W-1:0]  bmp_rdata,
  output logic               other_sel,
  output logic               other_we,
  input  logic [DATA_W-1:0]  other_rdata
);

  rgn_e              region;
  logic [DATA_W-1:0] rd_value;
  logic              mapped;
  logic [DATA_W-1:0] openbus_q;
  logic              strobe;
  logic              wr_only;

  cpbus_region_decode #(
    .ADDR_W  (ADDR_W),
    .IRAM_AW (IRAM_AW)
  ) u_decode (
    .addr   (cpu_addr),
    .region (region)
  );

  cpbus_read_mux #(
    .DATA_W (DATA_W)
  ) u_mux (
    .region      (region),
    .iram_rdata  (iram_rdata),
    .bmp_rdata   (bmp_rdata),
    .other_rdata (other_rdata),
    .openbus     (openbus_q),
    .value       (rd_value),
    .mapped      (mapped)
  );

  cpbus_openbus #(
    .DATA_W (DATA_W)
  ) u_openbus (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd        (cpu_rd),
    .wr        (cpu_wr),
    .mapped    (mapped),
    .rd_value  (rd_value),
    .wdata     (cpu_wdata),
    .openbus_q (openbus_q),
    .rdata_q   (cpu_rdata)
  );

  always_comb begin
    strobe    = cpu_rd | cpu_wr;
    wr_only   = cpu_wr & ~cpu_rd;
    iram_sel  = strobe && (region == RGN_IRAM);
    bmp_sel   = strobe && (region == RGN_BMP);
    other_sel = strobe && (region == RGN_OTHER);
    iram_we   = iram_sel & wr_only;
    bmp_we    = bmp_sel & wr_only;
    other_we  = other_sel & wr_only;
    iram_addr = cpu_addr[IRAM_AW-1:0];
    tgt_wdata = cpu_wdata;
  end

endmodule

// File: rtl/cpbus_decoder_chk.sv
module cpbus_decoder_chk #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_rd,
  input logic              cpu_wr,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              iram_sel,
  input logic              iram_we,
  input logic              bmp_sel,
  input logic              other_sel,
  input logic [DATA_W-1:0] ob_q
);

  logic in_hole;
  logic any_sel;
  logic wr_only;

  assign in_hole = ~cpu_addr[ADDR_W-2] && (cpu_addr[15:11] == 5'b00001);
  assign any_sel = iram_sel | bmp_sel | other_sel;
  assign wr_only = cpu_wr & ~cpu_rd;

  a_r5_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({iram_sel, bmp_sel, other_sel}));

  a_r5_idle_no_select: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_rd && !cpu_wr) |-> !any_sel);

  a_r2_hole_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    in_hole |-> (!iram_we && !any_sel));

  a_r2_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && in_hole) |=> (cpu_rdata == '0));

  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rd |=> $stable(cpu_rdata));

  a_r7_mapped_write_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_only && (any_sel || in_hole)) |=> (ob_q == $past(cpu_wdata)));

  a_r9_unmapped_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_only && !any_sel && !in_hole) |=> $stable(ob_q));

  a_r8_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !any_sel && !in_hole) |=> (cpu_rdata == $past(ob_q)));

  a_r6_read_loads_latch: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd |=> (ob_q == cpu_rdata));

endmodule

bind cpbus_decoder cpbus_decoder_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_addr  (cpu_addr),
  .cpu_rd    (cpu_rd),
  .cpu_wr    (cpu_wr),
  .cpu_wdata (cpu_wdata),
  .cpu_rdata (cpu_rdata),
  .iram_sel  (iram_sel),
  .iram_we   (iram_we),
  .bmp_sel   (bmp_sel),
  .other_sel (other_sel),
  .ob_q      (openbus_q)
);

// File: tb/cpbus_decoder_bench.sv
module cpbus_decoder_bench;

  logic        clk;
  logic        rst_n;
  logic [23:0] cpu_addr;
  logic        cpu_rd;
  logic        cpu_wr;
  logic [7:0]  cpu_wdata;
  logic [7:0]  cpu_rdata;
  logic [7:0]  tgt_wdata;
  logic        iram_sel, iram_we, bmp_sel, bmp_we, other_sel, other_we;
  logic [10:0] iram_addr;
  logic [7:0]  iram_rdata, bmp_rdata, other_rdata;

  logic [7:0]  iram_mem [0:2047];
  logic [7:0]  ob_model;
  int          checks;
  int          errors;
  int          cycles;
  bit          done;

  cpbus_decoder u_cpbus_decoder (
    .clk (clk), .rst_n (rst_n), .cpu_addr (cpu_addr), .cpu_rd (cpu_rd),
    .cpu_wr (cpu_wr), .cpu_wdata (cpu_wdata), .cpu_rdata (cpu_rdata),
    .tgt_wdata (tgt_wdata), .iram_sel (iram_sel), .iram_we (iram_we),
    .iram_addr (iram_addr), .iram_rdata (iram_rdata), .bmp_sel (bmp_sel),
    .bmp_we (bmp_we), .bmp_rdata (bmp_rdata), .other_sel (other_sel),
    .other_we (other_we), .other_rdata (other_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  assign iram_rdata  = iram_mem[iram_addr];
  assign bmp_rdata   = cpu_addr[7:0] ^ cpu_addr[15:8] ^ cpu_addr[23:16];
  assign other_rdata = ~cpu_addr[7:0];

  always @(posedge clk) if (iram_we) iram_mem[iram_addr] <= tgt_wdata;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected < 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // 0 none, 1 work RAM, 2 hole, 3 bitmap, 4 other
  function automatic int ref_class(input logic [23:0] a);
    int bank = int'(a[23:16]);
    int off  = int'(a[15:0]);
    bit lowb = (bank < 'h40) || (bank >= 'h80 && bank < 'hC0);
    if (lowb && off < 'h800) return 1;
    if (lowb && off < 'h1000) return 2;
    if (lowb && off >= 'h6000 && off < 'h8000) return 3;
    if (bank >= 'h60 && bank < 'h70) return 3;
    if (lowb && off >= 'h8000) return 4;
    if (bank >= 'hC0) return 4;
    return 0;
  endfunction

  function automatic logic [15:0] off_of(input int i);
    case (i)
      0: return 16'h0000; 1: return 16'h07FF; 2: return 16'h0800;
      3: return 16'h0FFF; 4: return 16'h1000; 5: return 16'h6000;
      6: return 16'h7FFF; default: return 16'h8000;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_sels(input int cls, input bit wr_only, input string req);
    logic [5:0] exp_s;
    logic [5:0] act_s;
    exp_s = {cls == 1, cls == 3, cls == 4,
             wr_only && cls == 1, wr_only && cls == 3, wr_only && cls == 4};
    act_s = {iram_sel, bmp_sel, other_sel, iram_we, bmp_we, other_we};
    chk(act_s == exp_s, req, int'(act_s), int'(exp_s));
  endtask

  // Read cycle: compute expected byte, check selects, check registered data
  task automatic do_read(input logic [23:0] a, input string req);
    int cls;
    logic [7:0] exp_v;
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1; cpu_wr = 1'b0;
    cls = ref_class(a);
    case (cls)
      1: exp_v = iram_mem[a[10:0]];
      2: exp_v = 8'h00;
      3: exp_v = a[7:0] ^ a[15:8] ^ a[23:16];
      4: exp_v = ~a[7:0];
      default: exp_v = ob_model;
    endcase
    #1 check_sels(cls, 1'b0, req);
    @(negedge clk);
    chk(cpu_rdata == exp_v, req, int'(cpu_rdata), int'(exp_v));
    ob_model = exp_v;
    cpu_rd = 1'b0;
  endtask

  task automatic do_write(input logic [23:0] a, input logic [7:0] d, input string req);
    int cls;
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b0; cpu_wr = 1'b1; cpu_wdata = d;
    cls = ref_class(a);
    #1 check_sels(cls, 1'b1, req);
    @(negedge clk);
    if (cls != 0) ob_model = d;
    cpu_wr = 1'b0;
  endtask

  initial begin
    checks = 0; errors = 0; cycles = 0; done = 0;
    for (int i = 0; i < 2048; i++) iram_mem[i] = 8'((i * 7 + 3) & 8'hFF);
    cpu_addr = '0; cpu_rd = 0; cpu_wr = 0; cpu_wdata = '0;
    ob_model = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: reset values
    chk(cpu_rdata == 8'h00, "R10 rdata after reset", int'(cpu_rdata), 0);
    do_read(24'h400000, "R10 latch after reset");

    // R5: no strobe, no selects
    @(negedge clk);
    cpu_addr = 24'h000100;
    #1 check_sels(0, 1'b0, "R5 idle selects");

    // Read sweep over all banks and offset classes (R1 R2 R3 R4 R6 R8)
    for (int b = 0; b < 256; b++) begin
      for (int o = 0; o < 8; o++) begin
        logic [23:0] a;
        a = {8'(b), off_of(o)};
        case (ref_class(a))
          1: do_read(a, "R1 work RAM read");
          2: do_read(a, "R2 hole read");
          3: do_read(a, "R3 bitmap read");
          4: do_read(a, "R4 other read");
          default: do_read(a, "R8 unmapped read (R6 latch from prior read)");
        endcase
      end
    end

    // Write sweep, latch observed by an unmapped read (R7 R9 R2)
    for (int b = 0; b < 256; b += 3) begin
      for (int o = 0; o < 8; o++) begin
        logic [23:0] a;
        logic [7:0] d;
        a = {8'(b), off_of(o)};
        d = 8'(b) ^ 8'(o * 37) ^ 8'h33;
        if (ref_class(a) == 0) begin
          do_write(a, d, "R9 unmapped write");
          do_read(24'h400000, "R9 latch unchanged");
        end else begin
          do_write(a, d, "R7 mapped write");
          do_read(24'h400000, "R7 latch takes write data");
        end
      end
    end

    // R1 read back of written work RAM, R2 hole write did not alias
    do_write(24'h000123, 8'hA5, "R1 work RAM write");
    do_write(24'h000923, 8'h5A, "R2 hole write");
    do_read(24'h000123, "R1 work RAM readback");

    // R9: simultaneous strobes act as read only
    do_read(24'h000010, "R6 read to set latch");
    @(negedge clk);
    cpu_addr = 24'h000010; cpu_rd = 1'b1; cpu_wr = 1'b1; cpu_wdata = 8'hEE;
    #1 check_sels(1, 1'b0, "R9 both strobes no write enable");
    @(negedge clk);
    chk(cpu_rdata == iram_mem[16], "R9 both strobes read data",
        int'(cpu_rdata), int'(iram_mem[16]));
    cpu_rd = 1'b0; cpu_wr = 1'b0;
    ob_model = iram_mem[16];
    do_read(24'h500000, "R9 latch after both strobes");

    // R11: rdata holds across idle and write cycles
    do_read(24'hC00042, "R11 setup read");
    repeat (3) @(negedge clk);
    chk(cpu_rdata == 8'hBD, "R11 hold idle", int'(cpu_rdata), 'hBD);
    do_write(24'h606000, 8'h11, "R11 write");
    chk(cpu_rdata == 8'hBD, "R11 hold across write", int'(cpu_rdata), 'hBD);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule